// File: doc/BRIEF.md
# SPI Serial Clock Divider with Selectable Range

This block derives the serial clock of an SPI master from the system clock while a transfer is running. The system clock is first halved. A range bit can insert a further divide by sixteen. A prescaler of configurable width then divides by its programmed value plus one, and a final toggle stage halves the rate again. The serial clock period is therefore `4*(PM+1)` system cycles in the fast range and `64*(PM+1)` cycles in the slow range, where PM is the prescaler value.

Along with the clock, the block produces two single-cycle strobes for a neighbouring shift engine. The shift strobe marks the edge on which outgoing data changes. The sample strobe marks the edge on which incoming data is captured. The clock-polarity input sets the level of the clock between transfers. The phase input selects which edge of each bit carries each strobe.

The range, prescaler, polarity and phase values are captured while the block is idle and are held for the whole transfer. Changes made during a transfer therefore take effect only at the next one.

Top module: `spi_baud_gen`

## Requirements
- R1: While `xfer_active_i` is low, every divide counter is held at its start value and both strobes are 0. After each such cycle, `sck_o` equals the `cpol_i` value sampled at that edge. Out of reset, `sck_o` is 0.
- R2: With `range_sel_i`=0, counting clock edges at which `xfer_active_i` is sampled high from 1, `sck_o` toggles at edge numbers n*2*(PM+1) only, for n = 1, 2, ….
- R3: With `range_sel_i`=1, `sck_o` toggles at edge numbers n*32*(PM+1) only, counted the same way as in R2.
- R4: The slowest setting, `range_sel_i`=1 with PM=15, gives a half period of 512 system cycles and a serial clock period of 1024 system cycles.
- R5: The first toggle of each transfer moves `sck_o` away from the idle level. Toggle n is a leading edge when n is odd and a trailing edge when n is even.
- R6: With `cpha_i`=0, `sample_stb_o` pulses on every leading edge and `shift_stb_o` on every trailing edge. Each pulse lasts exactly one cycle: the first cycle in which `sck_o` shows its new level.
- R7: With `cpha_i`=1, `shift_stb_o` pulses on leading edges and `sample_stb_o` on trailing edges, with the same timing as in R6.
- R8: Changes to `range_sel_i`, `prescale_i`, `cpol_i` or `cpha_i` while `xfer_active_i` is high do not alter the running clock. The values present on the last idle edge apply for the whole transfer.
- R9: `shift_stb_o` and `sample_stb_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_active_i | input | 1 | High while a transfer runs; low holds the clock idle and restarts the counters |
| range_sel_i | input | 1 | 1 inserts the extra divide by 16 |
| prescale_i | input | PM_W | Prescaler value PM; divides by PM+1 |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: sample on leading edge; 1: shift on leading edge |
| sck_o | output | 1 | Serial clock |
| shift_stb_o | output | 1 | One-cycle strobe for the edge on which data changes |
| sample_stb_o | output | 1 | One-cycle strobe for the edge on which data is captured |

## Verification
The divider is run with PM=0, PM=5 and PM=2 in the fast range. Together these separate a correct `PM+1` count from off-by-one counts and from a missing front-end halving. The slow range is run with PM=0, PM=2 and PM=15. This shows that the /16 stage sits in the chain and that the largest setting neither overflows nor wraps early. All four polarity and phase combinations are run, which tells a swapped strobe assignment apart from a wrong idle level or a wrong first-edge direction. Two further patterns check the hold and restart behaviour: a prescaler and range change in the middle of a transfer, and a transfer aborted before its first edge.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  localparam int unsigned DEF_PM_W     = 4;
  localparam int unsigned DEF_RANGE_LG = 4;

  typedef struct packed {
    logic range_sel;
    logic cpol;
    logic cpha;
  } baud_mode_t;
endpackage

// File: rtl/spi_baud_cfg_hold.sv
module spi_baud_cfg_hold
  import spi_baud_pkg::*;
#(
  parameter int unsigned PM_W = DEF_PM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  baud_mode_t       mode_i,
  input  logic [PM_W-1:0]  pm_i,
  output baud_mode_t       mode_o,
  output logic [PM_W-1:0]  pm_o
);
  baud_mode_t      mode_q;
  logic [PM_W-1:0] pm_q;
  logic            past_ok_q;

  // transparent while idle, frozen during a transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      pm_q   <= '0;
    end else if (!active_i) begin
      mode_q <= mode_i;
      pm_q   <= pm_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  assign mode_o = mode_q;
  assign pm_o   = pm_q;

  // R8
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && active_i && $past(active_i)) |-> ($stable(mode_q) && $stable(pm_q)));
endmodule

// File: rtl/spi_baud_range_div.sv
module spi_baud_range_div
  import spi_baud_pkg::*;
#(
  parameter int unsigned RANGE_LG = DEF_RANGE_LG
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic range_sel_i,
  output logic tick_o
);
  logic half_q;
  logic half_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        half_q <= 1'b0;
    else if (!active_i) half_q <= 1'b0;
    else                half_q <= ~half_q;
  end

  assign half_tick = active_i & half_q;

  generate
    if (RANGE_LG == 0) begin : g_no_range
      logic unused_sel;
      assign unused_sel = range_sel_i;
      assign tick_o     = half_tick;
    end else begin : g_range
      logic [RANGE_LG-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       cnt_q <= '0;
        else if (!active_i)                cnt_q <= '0;
        else if (half_tick && range_sel_i) cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = range_sel_i ? (half_tick && (&cnt_q)) : half_tick;

      // R1
      range_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_i |=> (cnt_q == '0 && !half_q));
    end
  endgenerate

  // R2
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/spi_baud_prescale.sv
module spi_baud_prescale
  import spi_baud_pkg::*;
#(
  parameter int unsigned PM_W = DEF_PM_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic            tick_i,
  input  logic [PM_W-1:0] pm_i,
  output logic            tick_o
);
  logic [PM_W-1:0] cnt_q;
  logic            wrap;

  assign wrap   = (cnt_q == pm_i);
  assign tick_o = tick_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  // R2
  pm_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (cnt_q <= pm_i));
endmodule

// File: rtl/spi_baud_edge_gen.sv
module spi_baud_edge_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic tick_i,
  input  logic idle_lvl_i,
  input  logic cpol_i,
  input  logic cpha_i,
  output logic sck_o,
  output logic shift_o,
  output logic sample_o
);
  logic sck_q, shift_q, sample_q, past_ok_q;
  logic lead;

  assign lead = (sck_q == cpol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
    end else if (!active_i) begin
      sck_q    <= idle_lvl_i;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
      if (tick_i) begin
        sck_q <= ~sck_q;
        // leading edge samples when cpha=0, shifts when cpha=1
        sample_q <= lead ^ cpha_i;
        shift_q  <= ~(lead ^ cpha_i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  assign sck_o    = sck_q;
  assign shift_o  = shift_q;
  assign sample_o = sample_q;

  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_q && sample_q));

  // R6
  strobe_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && (shift_q || sample_q)) |-> (sck_q != $past(sck_q)));

  // R1
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$past(active_i)) |-> (sck_q == $past(idle_lvl_i) && !shift_q && !sample_q));
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
#(
  parameter int unsigned PM_W     = DEF_PM_W,
  parameter int unsigned RANGE_LG = DEF_RANGE_LG
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            xfer_active_i,
  input  logic            range_sel_i,
  input  logic [PM_W-1:0] prescale_i,
  input  logic            cpol_i,
  input  logic            cpha_i,
  output logic            sck_o,
  output logic            shift_stb_o,
  output logic            sample_stb_o
);
  baud_mode_t      mode_in, mode_l;
  logic [PM_W-1:0] pm_l;
  logic            range_tick, bit_tick;

  assign mode_in = '{range_sel: range_sel_i, cpol: cpol_i, cpha: cpha_i};

  spi_baud_cfg_hold #(.PM_W(PM_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (xfer_active_i),
    .mode_i   (mode_in),
    .pm_i     (prescale_i),
    .mode_o   (mode_l),
    .pm_o     (pm_l)
  );

  spi_baud_range_div #(.RANGE_LG(RANGE_LG)) u_range (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (xfer_active_i),
    .range_sel_i (mode_l.range_sel),
    .tick_o      (range_tick)
  );

  spi_baud_prescale #(.PM_W(PM_W)) u_pm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (xfer_active_i),
    .tick_i   (range_tick),
    .pm_i     (pm_l),
    .tick_o   (bit_tick)
  );

  spi_baud_edge_gen u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (xfer_active_i),
    .tick_i     (bit_tick),
    .idle_lvl_i (cpol_i),
    .cpol_i     (mode_l.cpol),
    .cpha_i     (mode_l.cpha),
    .sck_o      (sck_o),
    .shift_o    (shift_stb_o),
    .sample_o   (sample_stb_o)
  );
endmodule

// File: tb/spi_baud_gen_bench.sv
module spi_baud_gen_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       act = 1'b0, rsel = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [3:0] pm = 4'd0;
  logic       sck, sh, sa;

  spi_baud_gen u_spi_baud_gen (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .xfer_active_i (act),
    .range_sel_i   (rsel),
    .prescale_i    (pm),
    .cpol_i        (cpol),
    .cpha_i        (cpha),
    .sck_o         (sck),
    .shift_stb_o   (sh),
    .sample_stb_o  (sa)
  );

  // behavioural reference
  int   m_k = 0, m_h = 2;
  logic m_sck = 0, m_sh = 0, m_sa = 0, m_cpha = 0;
  int   n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";
  bit   checking = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_k = 0; m_sck = 0; m_sh = 0; m_sa = 0; m_h = 2; m_cpha = 0;
    end else if (!act) begin
      m_k = 0; m_sck = cpol; m_sh = 0; m_sa = 0;
      m_h = (rsel ? 32 : 2) * (int'(pm) + 1);
      m_cpha = cpha;
    end else begin
      m_k++;
      m_sh = 0; m_sa = 0;
      if (m_k % m_h == 0) begin
        m_sck = ~m_sck;
        // odd toggle count = leading edge
        if (((m_k / m_h) % 2 == 1) ^ m_cpha) m_sa = 1;
        else                                  m_sh = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      n_chk++;
      if ({sck, sh, sa} !== {m_sck, m_sh, m_sa}) begin
        n_fail++;
        $display("FAIL %s cyc=%0d sck/shift/sample actual=%b%b%b expected=%b%b%b",
                 (m_k == 0) ? "R1" : tag, cyc, sck, sh, sa, m_sck, m_sh, m_sa);
      end
      n_chk++;
      if (sh === 1'b1 && sa === 1'b1) begin
        n_fail++;
        $display("FAIL R9 cyc=%0d actual shift&sample=1 expected 0", cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual cyc=%0d expected <150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_xfer(input logic p_cpol, input logic p_cpha, input logic p_rsel,
                          input int p_pm, input int n, input string t);
    @(negedge clk);
    cpol = p_cpol; cpha = p_cpha; rsel = p_rsel; pm = 4'(p_pm); tag = t;
    repeat (4) @(negedge clk);
    act = 1'b1;
    repeat (n) @(negedge clk);
    act = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    checking = 1'b1;
    repeat (3) @(negedge clk);   // R1: reset state
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_xfer(0, 0, 0, 0,   40,  "R2");
    run_xfer(0, 0, 0, 5,   100, "R6");
    run_xfer(1, 0, 0, 2,   60,  "R5");
    run_xfer(0, 1, 0, 3,   80,  "R7");
    run_xfer(1, 1, 0, 1,   50,  "R7");
    run_xfer(0, 0, 1, 0,   200, "R3");
    run_xfer(1, 1, 1, 2,   400, "R3");
    run_xfer(0, 0, 1, 15,  2100, "R4");
    run_xfer(0, 0, 0, 9,   7,   "R1");   // aborted before first edge
    run_xfer(0, 0, 0, 0,   12,  "R1");   // restart from fresh counters
    // R8: mid-transfer changes ignored
    @(negedge clk);
    tag = "R8"; pm = 4'd1; rsel = 1'b0; cpol = 1'b0; cpha = 1'b0;
    repeat (4) @(negedge clk);
    act = 1'b1;
    repeat (10) @(negedge clk);
    pm = 4'd7; rsel = 1'b1; cpha = 1'b1;
    repeat (50) @(negedge clk);
    act = 1'b0;
    repeat (4) @(negedge clk);
    run_xfer(0, 1, 1, 7, 600, "R8");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule